// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from a producer running on one clock to a consumer running on a second, unrelated clock. The producer presents a word together with a write strobe on its own clock. The consumer sees the oldest stored word on its data output at all times and pops it with a read strobe on its own clock. Each side has its own active-low asynchronous reset. Each side also has a registered status flag: a full flag on the producer side and an empty flag on the consumer side.

Each side keeps a binary position counter that is one bit wider than the storage address. The extra top bit flips every time the counter runs past the last slot. The Gray-coded form of each counter is the only value that crosses to the other clock. It passes through two receiving-clock flops on the way. The full and empty flags come from comparing a side's own next Gray value with the synchronized copy of the far side's value. Storage is a plain register array with a synchronous write and an asynchronous read.

Top module: `xclk_queue`

## Requirements
- R1: While either reset is held, and until the first accepted write, `rd_empty` is 1 and `wr_full` is 0.
- R2: Words leave on `rd_data` in exactly the order in which they were accepted, with none lost or repeated.
- R3: While `rd_empty` is 0, `rd_data` shows the oldest stored word without any read strobe. It stays steady until that word is popped.
- R4: With no reads, `wr_full` stays 0 through the first 2^ADDR_W - 1 accepted writes. It becomes 1 at the `wr_clk` edge that accepts write number 2^ADDR_W, and no further write is accepted.
- R5: `rd_empty` becomes 1 at the same `rd_clk` edge that pops the last stored word.
- R6: A write strobe while `wr_full` is 1 stores nothing and does not move the write position. A read strobe while `rd_empty` is 1 does not move the read position, so the next word written is still the one delivered.
- R7: After a write into an empty FIFO, `rd_empty` is still 1 after the first following `rd_clk` edge. It is 0 no later than the fourth following edge, because of the two-flop crossing plus the registered flag.
- R8: Both position counters wrap with their top bit flipping at each pass through the last slot. Their Gray forms change in at most one bit per clock. Order and capacity stay correct across many wraps, under any mix of write and read rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; taken only when `wr_full` is 0 |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Registered full flag, producer clock |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en | input | 1 | Read strobe; pops the head word when `rd_empty` is 0 |
| rd_data | output | DATA_W | Oldest stored word, shown without a clock |
| rd_empty | output | 1 | Registered empty flag, consumer clock |

## Verification
The bench uses a four-slot configuration and attacks the exact capacity boundary. A full-compare with a wrong bit inversion would either accept a fifth word and overwrite the head, or declare full one word early. It also strobes writes into a full queue and reads from an empty one. A design that let either strobe through would corrupt the head word or deliver a stale one. The crossing latency into an empty queue is bounded on both sides, which catches a missing or bypassed synchronizer stage. A sweep over every pairing of three write rates and three read rates runs each counter through many wraps, where a mishandled wrap bit shows up as lost or duplicated words.

// File: rtl/xq_pkg.sv
package xq_pkg;

    // Reflected binary code of a position value.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/xq_sync2.sv
module xq_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/xq_ptr.sv
module xq_ptr #(
    parameter int AW        = 4,
    parameter bit FULL_SIDE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [AW:0]   far_gray,
    output logic          flag,
    output logic [AW-1:0] addr,
    output logic [AW:0]   gray
);

    localparam int PW = AW + 1;

    logic [AW:0] bin;
    logic [AW:0] bin_nx;
    logic [AW:0] gray_nx;
    logic        flag_nx;
    logic        adv;

    assign adv     = step & ~flag;
    assign bin_nx  = bin + PW'(adv);
    assign gray_nx = PW'(xq_pkg::to_gray(32'(bin_nx)));
    assign addr    = bin[AW-1:0];

    generate
        if (FULL_SIDE) begin : g_full
            // Writer one lap ahead: the two top Gray bits are inverted and the rest are equal.
            assign flag_nx = (gray_nx == {~far_gray[AW:AW-1], far_gray[AW-2:0]});
        end else begin : g_empty
            assign flag_nx = (gray_nx == far_gray);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
            flag <= ~FULL_SIDE;
        end else begin
            bin  <= bin_nx;
            gray <= gray_nx;
            flag <= flag_nx;
        end
    end

    p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && step) |=> (bin == $past(bin)));

    p_gray_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(gray ^ $past(gray)) <= 1));

    p_wrap_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (bin[AW-1:0] == '1)) |=> (bin[AW] != $past(bin[AW])));

endmodule

// File: rtl/xq_mem.sv
module xq_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

    p_write_lands_r2: assert property (@(posedge clk)
        we |=> (cells[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/xclk_queue.sv
module xclk_queue #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     rd_gray_at_wr;
    logic [PW-1:0]     wr_gray_at_rd;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              mem_we;

    assign mem_we = wr_en & ~wr_full;

    xq_sync2 #(.W(PW)) u_rd2wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_at_wr)
    );

    xq_sync2 #(.W(PW)) u_wr2rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_at_rd)
    );

    xq_ptr #(.AW(ADDR_W), .FULL_SIDE(1'b1)) u_wptr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .step     (wr_en),
        .far_gray (rd_gray_at_wr),
        .flag     (wr_full),
        .addr     (wr_addr),
        .gray     (wr_gray)
    );

    xq_ptr #(.AW(ADDR_W), .FULL_SIDE(1'b0)) u_rptr (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .step     (rd_en),
        .far_gray (wr_gray_at_rd),
        .flag     (rd_empty),
        .addr     (rd_addr),
        .gray     (rd_gray)
    );

    xq_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk   (wr_clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/xclk_queue_tb_top.sv
`timescale 1ns/1ps
module xclk_queue_tb_top;

    localparam int      DW        = 8;
    localparam int      AW        = 2;
    localparam int      DEPTH     = 1 << AW;
    localparam realtime WR_PERIOD = 10.0;
    localparam realtime RD_PERIOD = 13.7;
    localparam realtime WATCHDOG  = 1000000.0;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full;
    logic          rd_empty;

    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model_q[$];

    always #(WR_PERIOD / 2.0) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2.0) rd_clk = ~rd_clk;

    xclk_queue #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_one(input logic [DW-1:0] d, output bit took);
        @(negedge wr_clk);
        took    = !wr_full;
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (took) model_q.push_back(d);
    endtask

    task automatic rd_one(output logic [DW-1:0] got);
        @(negedge rd_clk);
        got   = rd_data;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic stream(input int wk, input int rk, input int n);
        fork
            begin : writer
                int sent = 0;
                int cnt  = 0;
                while (sent < n) begin
                    @(negedge wr_clk);
                    cnt++;
                    if (cnt % wk == 0) begin
                        wr_en   = 1'b1;
                        wr_data = DW'(sent * 37 + wk * 11 + rk);
                        if (!wr_full) begin
                            model_q.push_back(wr_data);
                            sent++;
                        end
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin : reader
                int got = 0;
                int cnt = 0;
                while (got < n) begin
                    @(negedge rd_clk);
                    cnt++;
                    if (cnt % rk == 0) begin
                        rd_en = 1'b1;
                        if (!rd_empty) begin
                            if (model_q.size() == 0) begin
                                check(1'b0, "R2", int'(rd_data), 0);
                            end else begin
                                logic [DW-1:0] exp_w;
                                exp_w = model_q.pop_front();
                                check(rd_data == exp_w, "R8", int'(rd_data), int'(exp_w));
                            end
                            got++;
                        end
                    end else begin
                        rd_en = 1'b0;
                    end
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
            end
        join
    endtask

    initial begin : watchdog
        #(WATCHDOG);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        bit            took;
        logic [DW-1:0] got;
        logic [DW-1:0] exp_w;
        int            edges;

        repeat (3) @(negedge rd_clk);
        // R1: flags during reset
        check(rd_empty == 1'b1, "R1", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R1", int'(wr_full), 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        check(rd_empty == 1'b1, "R1", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R1", int'(wr_full), 0);

        // R4: fill to exact capacity with no reads
        for (int i = 0; i < DEPTH; i++) begin
            wr_one(DW'(8'h10 + i), took);
            check(took, "R4", int'(took), 1);
            check(wr_full == (i == DEPTH - 1), "R4", int'(wr_full), int'(i == DEPTH - 1));
        end
        // R6: write strobe while full is dropped
        wr_one(8'hEE, took);
        check(!took && wr_full, "R6", int'(wr_full), 1);

        // R3: head visible without a read strobe, steady
        repeat (4) @(negedge rd_clk);
        check(rd_empty == 1'b0, "R3", int'(rd_empty), 0);
        check(rd_data == 8'h10, "R3", int'(rd_data), 8'h10);
        repeat (3) @(negedge rd_clk);
        check(rd_data == 8'h10, "R3", int'(rd_data), 8'h10);

        // R2 / R5: drain, empty rises on the last pop
        for (int i = 0; i < DEPTH; i++) begin
            rd_one(got);
            exp_w = model_q.pop_front();
            check(got == exp_w, "R2", int'(got), int'(exp_w));
            check(rd_empty == (i == DEPTH - 1), "R5", int'(rd_empty), int'(i == DEPTH - 1));
        end
        repeat (6) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R6", int'(rd_empty), 1);
        check(model_q.size() == 0, "R6", model_q.size(), 0);

        // R6: read strobes while empty
        @(negedge rd_clk) rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en = 1'b0;

        // R7: crossing latency into an empty queue
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = 8'h5A;
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0;
        model_q.push_back(8'h5A);
        check(rd_empty == 1'b1, "R7", int'(rd_empty), 1);
        @(posedge rd_clk);
        #1;
        check(rd_empty == 1'b1, "R7", int'(rd_empty), 1);
        edges = 1;
        while (rd_empty && edges < 4) begin
            @(posedge rd_clk);
            #1;
            edges++;
        end
        check(rd_empty == 1'b0, "R7", int'(rd_empty), 0);
        @(negedge rd_clk);
        check(rd_data == 8'h5A, "R6", int'(rd_data), 8'h5A);
        rd_one(got);
        exp_w = model_q.pop_front();
        check(got == exp_w, "R2", int'(got), int'(exp_w));

        // R8: rate sweep across many wraps
        for (int wk = 1; wk <= 3; wk++) begin
            for (int rk = 1; rk <= 3; rk++) begin
                stream(wk, rk, 6 * DEPTH);
                repeat (6) @(negedge rd_clk);
                check(rd_empty == 1'b1, "R8", int'(rd_empty), 1);
                check(model_q.size() == 0, "R2", model_q.size(), 0);
                check(wr_full == 1'b0, "R8", int'(wr_full), 0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule